// File: doc/BRIEF.md
# Quasi-Bidirectional Port Block with Latch or Pin Readback

This block holds the general-purpose I/O ports of a small 8-bit controller core behind a register-style access path. Six bidirectional ports (numbered 0 to 5) each own an 8-bit output latch. A seventh port (number 6) is input-only and has no latch. The core addresses one port per cycle through a select code. A read source strobe from the instruction decoder chooses what a read returns: the latch contents or the synchronized pin levels.

Read-modify-write accesses always take the latch as their operand and store the result back into the same latch. A pin that is held low from outside therefore never leaks into a latch update. Ports 1 to 5 are quasi-bidirectional: a latch 0 drives the pin low, and a latch 1 leaves it on an internal pullup. Port 0 has no pullup and behaves as open drain. It can also be handed to an external bus source that drives both levels. Pin levels are resolved inside the block from its own drivers and from an external driver model, with low winning over high.

Top module: `gpio_sfr_ports`

## Requirements
- R1: After reset every output latch of ports 0 to 5 holds 0xFF, and a latch read of any of them returns 0xFF.
- R2: When `acc_sel` is 0 to 5 and `rd_src_latch` or `acc_rmw` is high, `rd_data` shows that port's latch in the same cycle.
- R3: When `acc_sel` is 0 to 5 and neither strobe is high, `rd_data` shows that port's `pad_level` byte as it stood two rising edges earlier. For `acc_sel` = 6, `rd_data` always shows the port 6 levels with the same delay, whatever the strobes are. For `acc_sel` = 7, `rd_data` is 0.
- R4: When `acc_wr` is high, `acc_rmw` is low and `acc_sel` is 0 to 5, the selected latch takes `acc_wdata` at the next rising edge. An access with `acc_sel` of 6 or 7 changes no latch.
- R5: When `acc_rmw` is high and `acc_sel` is 0 to 5, the selected latch becomes op(latch, `acc_wdata`) at the next rising edge, whatever the pins show. The op codes are: `acc_op` 00 AND, 01 OR, 10 XOR, 11 replace. `acc_rmw` takes precedence over `acc_wr`.
- R6: On ports 1 to 5 (pad bits 8 to 47), a latch bit of 0 gives `pad_oe`=1 and `pad_do`=0. A latch bit of 1 gives `pad_oe`=0, and the pin reads 1 unless an external driver pulls it low.
- R7: On port 0 (pad bits 0 to 7) outside bus mode, `pad_do` is 0 and `pad_oe` is the inverse of the latch. An undriven, released bit takes the external value, or 0 if nothing drives it.
- R8: With `bus_mode` high, port 0 drives `pad_oe`=`bus_oe` and `pad_do`=`bus_dout`. Its latch is not used for this and is not changed.
- R9: Port 6 (pad bits 48 to 55) has no driver and no pullup: its level is the external value, or 0 when undriven.
- R10: Pad resolution: a bit is 0 if any driver (the block or external) drives it low. Otherwise it is 1 if any driver drives high or a pullup applies. Otherwise it floats to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 3 | Port select: 0-5 bidirectional, 6 input-only, 7 none |
| acc_wr | input | 1 | Plain write strobe |
| acc_rmw | input | 1 | Read-modify-write strobe; also selects latch readback |
| acc_op | input | 2 | Read-modify-write operation |
| acc_wdata | input | 8 | Write data or operand |
| rd_src_latch | input | 1 | Read source: 1 latch, 0 pins |
| rd_data | output | 8 | Read result |
| bus_mode | input | 1 | Hand port 0 to the bus source |
| bus_oe | input | 8 | Bus output enables for port 0 |
| bus_dout | input | 8 | Bus drive values for port 0 |
| ext_en | input | 56 | External driver enable per pad bit |
| ext_val | input | 56 | External driver value per pad bit |
| pad_oe | output | 48 | Block output enable, ports 0-5 |
| pad_do | output | 48 | Block drive value, ports 0-5 |
| pad_level | output | 56 | Resolved pad level, ports 0-6 |

## Verification
The main function is tried with three kinds of pattern. In the first, the latch and the pins agree. In the second, external drivers pull latched-high pins low, so a latch read and a pin read of the same port must differ; this also shows that an AND with 0xAA updates the latch from the latch value alone. In the third, bus mode and port 6 are driven while latch accesses continue, which shows that the bus drive and the input-only port stay independent of the latches. A long stretch of mixed random accesses and external loads then checks every output against a behavioural model on every cycle.

// File: rtl/gpio_sfr_ports.sv
module gpio_sfr_ports #(
  parameter int   W           = 8,
  parameter int   NBI         = 6,
  parameter logic FLOAT_LEVEL = 1'b0,
  localparam int  NB          = NBI * W,
  localparam int  NALL        = (NBI + 1) * W,
  localparam int  SELW        = $clog2(NBI + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] acc_sel,
  input  logic            acc_wr,
  input  logic            acc_rmw,
  input  logic [1:0]      acc_op,
  input  logic [W-1:0]    acc_wdata,
  input  logic            rd_src_latch,
  output logic [W-1:0]    rd_data,
  input  logic            bus_mode,
  input  logic [W-1:0]    bus_oe,
  input  logic [W-1:0]    bus_dout,
  input  logic [NALL-1:0] ext_en,
  input  logic [NALL-1:0] ext_val,
  output logic [NB-1:0]   pad_oe,
  output logic [NB-1:0]   pad_do,
  output logic [NALL-1:0] pad_level
);

  localparam logic [SELW-1:0] SEL_IN = SELW'(NBI);

  logic [NB-1:0]   latch;
  logic [NALL-1:0] sync1, sync2;
  logic            sel_bi;
  int              idx;
  logic [W-1:0]    cur_latch, rmw_res;

  assign sel_bi    = acc_sel < SEL_IN;
  assign idx       = sel_bi ? int'(acc_sel) : 0;
  assign cur_latch = latch[idx*W +: W];

  always_comb begin
    case (acc_op)
      2'b00:   rmw_res = cur_latch & acc_wdata;
      2'b01:   rmw_res = cur_latch | acc_wdata;
      2'b10:   rmw_res = cur_latch ^ acc_wdata;
      default: rmw_res = acc_wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '1;
    end else if (sel_bi && (acc_rmw || acc_wr)) begin
      latch[idx*W +: W] <= acc_rmw ? rmw_res : acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_level;
      sync2 <= sync1;
    end
  end

  always_comb begin
    if (sel_bi)
      rd_data = (rd_src_latch || acc_rmw) ? cur_latch : sync2[idx*W +: W];
    else if (acc_sel == SEL_IN)
      rd_data = sync2[NB +: W];
    else
      rd_data = '0;
  end

  for (genvar p = 0; p < NBI; p++) begin : g_drv
    if (p == 0) begin : g_p0
      assign pad_oe[W-1:0] = bus_mode ? bus_oe   : ~latch[W-1:0];
      assign pad_do[W-1:0] = bus_mode ? bus_dout : '0;
    end else begin : g_pq
      assign pad_oe[p*W +: W] = ~latch[p*W +: W];
      assign pad_do[p*W +: W] = '0;
    end
  end

  for (genvar i = 0; i < NALL; i++) begin : g_pad
    localparam int  P      = i / W;
    localparam bit  PULLUP = (P >= 1) && (P < NBI);
    logic drv_lo, drv_hi;
    if (i < NB) begin : g_bi
      assign drv_lo = (pad_oe[i] & ~pad_do[i]) | (ext_en[i] & ~ext_val[i]);
      assign drv_hi = (pad_oe[i] &  pad_do[i]) | (ext_en[i] &  ext_val[i]);
    end else begin : g_in
      assign drv_lo = ext_en[i] & ~ext_val[i];
      assign drv_hi = ext_en[i] &  ext_val[i];
    end
    assign pad_level[i] = drv_lo ? 1'b0 : drv_hi ? 1'b1 : (PULLUP ? 1'b1 : FLOAT_LEVEL);
  end

endmodule

// File: rtl/gpio_sfr_ports_chk.sv
module gpio_sfr_ports_chk #(
  parameter int   W           = 8,
  parameter int   NBI         = 6,
  parameter logic FLOAT_LEVEL = 1'b0,
  localparam int  NB          = NBI * W,
  localparam int  NALL        = (NBI + 1) * W,
  localparam int  SELW        = $clog2(NBI + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] acc_sel,
  input logic            acc_wr,
  input logic            acc_rmw,
  input logic [W-1:0]    acc_wdata,
  input logic            rd_src_latch,
  input logic [W-1:0]    rd_data,
  input logic            bus_mode,
  input logic [W-1:0]    bus_oe,
  input logic [W-1:0]    bus_dout,
  input logic [NALL-1:0] ext_en,
  input logic [NALL-1:0] ext_val,
  input logic [NALL-1:0] pad_level,
  input logic [NB-1:0]   latch
);

  localparam logic [SELW-1:0] SEL_IN = SELW'(NBI);

  logic         seen_q, wr_q;
  int           wr_idx_q;
  logic [W-1:0] wr_data_q;
  int           sel_i;

  assign sel_i = (acc_sel < SEL_IN) ? int'(acc_sel) : 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      wr_q      <= 1'b0;
      wr_idx_q  <= 0;
      wr_data_q <= '0;
    end else begin
      seen_q    <= 1'b1;
      wr_q      <= acc_wr && !acc_rmw && (acc_sel < SEL_IN);
      wr_idx_q  <= sel_i;
      wr_data_q <= acc_wdata;
    end
  end

  p_reset_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> latch == '1);

  p_latch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_sel < SEL_IN) && (rd_src_latch || acc_rmw)) |-> rd_data == latch[sel_i*W +: W]);

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> latch[wr_idx_q*W +: W] == wr_data_q);

  p_no_latch_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel >= SEL_IN) |=> $stable(latch));

  p_pullup_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch[NB-1:W] & ~(ext_en[NB-1:W] & ~ext_val[NB-1:W])) & ~pad_level[NB-1:W]) == '0);

  p_bus_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && (&bus_oe) && !(|ext_en[W-1:0])) |-> pad_level[W-1:0] == bus_dout);

  p_floating_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ext_en[NALL-1:NB]) |-> pad_level[NALL-1:NB] == {W{FLOAT_LEVEL}});

  p_low_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_en & ~ext_val) & pad_level) == '0);

endmodule

bind gpio_sfr_ports gpio_sfr_ports_chk #(.W(W), .NBI(NBI), .FLOAT_LEVEL(FLOAT_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_rmw(acc_rmw),
  .acc_wdata(acc_wdata), .rd_src_latch(rd_src_latch), .rd_data(rd_data),
  .bus_mode(bus_mode), .bus_oe(bus_oe), .bus_dout(bus_dout), .ext_en(ext_en),
  .ext_val(ext_val), .pad_level(pad_level), .latch(latch)
);

// File: tb/test_gpio_sfr_ports.sv
`timescale 1ns/1ps
module test_gpio_sfr_ports;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic        acc_wr = 1'b0, acc_rmw = 1'b0, rd_src_latch = 1'b0, bus_mode = 1'b0;
  logic [1:0]  acc_op = '0;
  logic [7:0]  acc_wdata = '0, bus_oe = '0, bus_dout = '0;
  logic [55:0] ext_en = '0, ext_val = '0;
  logic [7:0]  rd_data;
  logic [47:0] pad_oe, pad_do;
  logic [55:0] pad_level;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_sfr_ports i_gpio_sfr_ports (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr), .acc_rmw(acc_rmw),
    .acc_op(acc_op), .acc_wdata(acc_wdata), .rd_src_latch(rd_src_latch), .rd_data(rd_data),
    .bus_mode(bus_mode), .bus_oe(bus_oe), .bus_dout(bus_dout), .ext_en(ext_en),
    .ext_val(ext_val), .pad_oe(pad_oe), .pad_do(pad_do), .pad_level(pad_level)
  );

  // behavioural reference
  logic [7:0]  m_lat [6];
  logic [55:0] m_s1 = '0, m_s2 = '0;
  logic [47:0] e_oe, e_do;
  logic [55:0] e_lev;
  logic [7:0]  e_rd;

  initial for (int p = 0; p < 6; p++) m_lat[p] = 8'hFF;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  task automatic model_eval();
    for (int i = 0; i < 56; i++) begin
      int p = i / 8;
      int b = i % 8;
      bit oe = 0, dv = 0, lo, hi;
      if (p < 6) begin
        if (p == 0 && bus_mode) begin oe = bus_oe[b]; dv = bus_dout[b]; end
        else begin oe = !m_lat[p][b]; dv = 0; end
        e_oe[i] = oe; e_do[i] = dv;
      end
      lo = (oe && !dv) || (ext_en[i] && !ext_val[i]);
      hi = (oe && dv)  || (ext_en[i] && ext_val[i]);
      e_lev[i] = lo ? 1'b0 : hi ? 1'b1 : (p >= 1 && p <= 5);
    end
    if (acc_sel < 6) e_rd = (rd_src_latch || acc_rmw) ? m_lat[acc_sel] : m_s2[acc_sel*8 +: 8];
    else if (acc_sel == 6) e_rd = m_s2[55:48];
    else e_rd = 8'h00;
  endtask

  always @(negedge clk) begin
    model_eval();
    if (rst_n) begin
      chk((acc_sel < 6 && (rd_src_latch || acc_rmw)) ? "R2 rd_data latch" : "R3 rd_data pins", 64'(rd_data), 64'(e_rd));
      chk(bus_mode ? "R8 port0 oe/do" : "R7 port0 oe/do", {pad_oe[7:0], pad_do[7:0]}, {e_oe[7:0], e_do[7:0]});
      chk("R6 quasi ports oe", 64'(pad_oe[47:8]), 64'(e_oe[47:8]));
      chk("R6 quasi ports do", 64'(pad_do[47:8]), 64'(e_do[47:8]));
      chk("R10 pad levels", 64'(pad_level[47:0]), 64'(e_lev[47:0]));
      chk("R9 port6 levels", 64'(pad_level[55:48]), 64'(e_lev[55:48]));
      m_s2 = m_s1;
      m_s1 = e_lev;
      if (acc_sel < 6) begin
        if (acc_rmw) begin
          case (acc_op)
            2'b00: m_lat[acc_sel] = m_lat[acc_sel] & acc_wdata;
            2'b01: m_lat[acc_sel] = m_lat[acc_sel] | acc_wdata;
            2'b10: m_lat[acc_sel] = m_lat[acc_sel] ^ acc_wdata;
            default: m_lat[acc_sel] = acc_wdata;
          endcase
        end else if (acc_wr) m_lat[acc_sel] = acc_wdata;
      end
    end else begin
      for (int p = 0; p < 6; p++) m_lat[p] = 8'hFF;
      m_s1 = '0; m_s2 = '0;
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic idle();
    acc_wr = 0; acc_rmw = 0; rd_src_latch = 0; acc_sel = 3'd7;
  endtask

  initial begin : watchdog
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1: every latch reads 0xFF after reset
    for (int p = 0; p < 6; p++) begin
      tick(); acc_sel = 3'(p); rd_src_latch = 1; #9;
      chk("R1 reset latch", 64'(rd_data), 64'h FF);
    end
    // R4: plain write lands at next edge
    tick(); acc_sel = 3'd3; rd_src_latch = 0; acc_wr = 1; acc_wdata = 8'h5A;
    tick(); acc_wr = 0; rd_src_latch = 1; #9;
    chk("R4 write port3", 64'(rd_data), 64'h5A);
    // R4: write to input-only port and to code 7 changes nothing
    tick(); acc_sel = 3'd6; acc_wr = 1; acc_wdata = 8'h00;
    tick(); acc_sel = 3'd7;
    tick(); acc_wr = 0; acc_sel = 3'd3; #9;
    chk("R4 ignored write", 64'(rd_data), 64'h5A);
    // R3/R5/R10: loaded pins on port 2 and AND 0xAA
    tick(); acc_sel = 3'd2; rd_src_latch = 0; ext_en[23:16] = 8'h0F; ext_val[23:16] = 8'h00;
    tick(); tick(); tick(); #9;
    chk("R3 pin read loaded", 64'(rd_data), 64'hF0);
    tick(); acc_rmw = 1; acc_op = 2'b00; acc_wdata = 8'hAA; #9;
    chk("R2 rmw reads latch", 64'(rd_data), 64'hFF);
    tick(); acc_rmw = 0; rd_src_latch = 1; #9;
    chk("R5 and 0xAA result", 64'(rd_data), 64'hAA);
    chk("R6 oe from latch", 64'(pad_oe[23:16]), 64'h55);
    tick(); acc_rmw = 1; acc_op = 2'b10; acc_wdata = 8'h0F;
    tick(); acc_rmw = 0; #9;
    chk("R5 xor result", 64'(rd_data), 64'hA5);
    ext_en = '0;
    // R7: port0 released with no drive floats low; then follows outside
    tick(); idle(); #9;
    chk("R7 port0 floating", 64'(pad_level[7:0]), 64'h00);
    ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'h3C; #1;
    chk("R7 port0 external", 64'(pad_level[7:0]), 64'h3C);
    ext_en[7:0] = 8'h00;
    // R8: bus mode drives both levels, latch untouched
    tick(); bus_mode = 1; bus_oe = 8'hFF; bus_dout = 8'h96; acc_sel = 3'd0; rd_src_latch = 1; #9;
    chk("R8 bus drive", 64'(pad_level[7:0]), 64'h96);
    chk("R8 latch kept", 64'(rd_data), 64'hFF);
    tick(); bus_mode = 0;
    // R9: input-only port, latch strobe has no effect
    ext_en[55:48] = 8'hFF; ext_val[55:48] = 8'h81; acc_sel = 3'd6; rd_src_latch = 1;
    tick(); tick(); tick(); #9;
    chk("R9 port6 read", 64'(rd_data), 64'h81);
    // random mix, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      tick();
      acc_sel = 3'($urandom_range(0, 7));
      acc_wr = ($urandom_range(0, 3) == 0);
      acc_rmw = ($urandom_range(0, 4) == 0);
      acc_op = 2'($urandom);
      acc_wdata = 8'($urandom);
      rd_src_latch = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) bus_mode = ~bus_mode;
      bus_oe = 8'($urandom); bus_dout = 8'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        ext_en  = {$urandom, $urandom} & {$urandom, $urandom};
        ext_val = {$urandom, $urandom};
      end
    end
    tick(); idle();
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule